// File: doc/BRIEF.md
# Masked Error Interrupt Controller

This block gathers network error and status conditions into a sticky 16-bit status word and filters them through a per-bit mask and a small set of enable bits. The result drives a single level interrupt request to a host processor. A one-shot arm latch means that once the request has gone out, further events only update the status word. A new request can be raised only after the host writes the status register.

The host reaches the control, status, mask and two vector registers through a simple write strobe and address port, with a combinational read path. A separate vector output lets the interrupt handler tell an error interrupt from a memory-update interrupt without decoding the status word.

Status bit map (positions are decoded by software): 0 transmit queue full, 1 transmit queue not empty, 2 transmit queue seven-eighths full, 4 interrupt queue full, 5 protocol violation, 6 carrier loss, 7 malformed message, 8 receive overrun, 9 transmit retry, 10 retry timeout, 11 redundant path fault, 12 counter/timer event, 15 optical bypass open, 13 memory-update pending, 14 interrupts enabled, 3 unused.

Top module: `err_irq_ctrl`

## Requirements
- R1: After reset, control, status and mask read 0, both vectors read 0, the interrupt output is low and the arm latch is set.
- R2: A 1 on a condition input at a clock edge sets the matching status bit, which stays 1 until a status write puts 1 in that position. If a set and a clear reach the same bit in one cycle, the set wins.
- R3: Condition inputs 3, 13 and 14 have no effect on the status word, and mask bits 3, 13 and 14 always read 0. Status bit 14 changes only by status write, taking the written value; status bit 3 reads 0.
- R4: An error cause exists when a status bit that is masked in is set. The interrupt rises one cycle after an error cause is present together with control bit 7, control bit 3 and status bit 14. It stays low if control bit 3 or status bit 14 is 0.
- R5: Control bit 5 works as an alternative to control bit 7 for letting a masked-in condition raise the interrupt.
- R6: A condition whose mask bit is 0 never raises the interrupt.
- R7: Once high, the interrupt holds through further events. Any status write drops it on the next edge and re-arms the latch. It rises again one cycle later only if a qualifying cause is still present.
- R8: A pulse on the update input sets status bit 13. That bit raises the interrupt when control bit 3 and status bit 14 are 1, without needing control bit 7 or 5.
- R9: The vector output shows the error vector while an enabled error cause exists, otherwise the data vector. When both an error and an update are pending, the error vector wins.
- R10: Register addresses: 0 control, 1 status, 2 mask, 3 data vector, 4 error vector. Only control bits 3, 5 and 7 are stored; the others read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 16 | Condition event pulses, one per status bit |
| upd_i | input | 1 | Memory-update event pulse |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address for write and read |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Level interrupt request to the host |
| vec_o | output | VW | Interrupt vector for the handler |

## Verification
The assertions assume that condition and update pulses are sampled as plain levels at each edge. They also assume that a status write is the only re-arm path, so no other register write is expected to move the interrupt. The stimulus drives every input at the falling edge and returns strobes and pulses to zero after one cycle. As a result, each status write is a single deliberate re-arm, and the retention and hold properties see idle cycles between events.

// File: rtl/err_irq_ctrl.sv
module err_irq_ctrl #(
  parameter int VW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cond_i,
  input  logic          upd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic          irq_o,
  output logic [VW-1:0] vec_o
);
  localparam logic [15:0] ERR_BITS = 16'h9FF7;
  localparam logic [15:0] CTL_BITS = 16'h00A8;
  localparam int UPD_BIT = 13;
  localparam int IEN_BIT = 14;
  localparam logic [AW-1:0] A_CTL  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_DVEC = AW'(3);
  localparam logic [AW-1:0] A_EVEC = AW'(4);

  logic [15:0]   ctl_q, stat_q, mask_q, stat_d;
  logic [VW-1:0] dvec_q, evec_q;
  logic          armed_q, irq_q;

  wire wr_stat   = wr_i && (addr_i == A_STAT);
  wire err       = |(stat_q & mask_q & ERR_BITS);
  wire err_cause = err && (ctl_q[7] || ctl_q[5]);
  wire gate      = ctl_q[3] && stat_q[IEN_BIT];
  wire fire      = gate && (err_cause || stat_q[UPD_BIT]);

  always_comb begin
    logic [15:0] setv, clrv;
    setv = cond_i & ERR_BITS;
    setv[UPD_BIT] = upd_i;
    clrv = wr_stat ? (wdata_i & ~(16'h1 << IEN_BIT)) : 16'h0;
    stat_d = (stat_q & ~clrv) | setv;
    stat_d[IEN_BIT] = wr_stat ? wdata_i[IEN_BIT] : stat_q[IEN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      stat_q  <= '0;
      mask_q  <= '0;
      dvec_q  <= '0;
      evec_q  <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (wr_i && addr_i == A_CTL)  ctl_q  <= wdata_i & CTL_BITS;
      if (wr_i && addr_i == A_MASK) mask_q <= wdata_i & ERR_BITS;
      if (wr_i && addr_i == A_DVEC) dvec_q <= wdata_i[VW-1:0];
      if (wr_i && addr_i == A_EVEC) evec_q <= wdata_i[VW-1:0];
      if (wr_stat) begin
        irq_q   <= 1'b0;
        armed_q <= 1'b1;
      end else if (armed_q && fire) begin
        irq_q   <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_CTL:   rdata_o = ctl_q;
      A_STAT:  rdata_o = stat_q;
      A_MASK:  rdata_o = mask_q;
      A_DVEC:  rdata_o = 16'(dvec_q);
      A_EVEC:  rdata_o = 16'(evec_q);
      default: rdata_o = 16'h0;
    endcase
  end

  assign irq_o = irq_q;
  assign vec_o = err_cause ? evec_q : dvec_q;

  AST_RISE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(ctl_q[3] && stat_q[IEN_BIT])); // R4
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(err || stat_q[UPD_BIT])); // R6
  AST_REARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> !irq_q); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !wr_stat) |=> irq_q); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q) & ERR_BITS) == ($past(stat_q) & ERR_BITS))); // R2
  AST_IEN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(stat_q[IEN_BIT])); // R3
endmodule

// File: tb/err_irq_ctrl_test.sv
module err_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cond_i = '0;
  logic        upd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  logic [7:0]  vec_o;
  int checks = 0;
  int errors = 0;

  err_irq_ctrl #(.VW(8), .AW(3)) uut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .upd_i(upd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .vec_o(vec_o));

  always #2 clk = ~clk;

  // {req, wr, addr, wdata, cond, upd, exp_irq, exp_rd, exp_vec}
  localparam logic [65:0] TBL [0:28] = '{
    {4'd10, 1'b1, 3'd3, 16'h005A, 16'h0000, 1'b0, 1'b0, 16'h005A, 8'h5A}, // R10
    {4'd10, 1'b1, 3'd4, 16'h00C3, 16'h0000, 1'b0, 1'b0, 16'h00C3, 8'h5A}, // R10
    {4'd3,  1'b1, 3'd2, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 16'h9FF7, 8'h5A}, // R3
    {4'd10, 1'b1, 3'd0, 16'h00FF, 16'h0000, 1'b0, 1'b0, 16'h00A8, 8'h5A}, // R10
    {4'd4,  1'b0, 3'd1, 16'h0000, 16'h0020, 1'b0, 1'b0, 16'h0020, 8'hC3}, // R4
    {4'd4,  1'b1, 3'd1, 16'h4000, 16'h0000, 1'b0, 1'b0, 16'h4020, 8'hC3}, // R4
    {4'd4,  1'b0, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h4020, 8'hC3}, // R4
    {4'd7,  1'b0, 3'd1, 16'h0000, 16'h0100, 1'b0, 1'b1, 16'h4120, 8'hC3}, // R7
    {4'd7,  1'b1, 3'd1, 16'h4020, 16'h0000, 1'b0, 1'b0, 16'h4100, 8'hC3}, // R7
    {4'd7,  1'b0, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h4100, 8'hC3}, // R7
    {4'd2,  1'b1, 3'd1, 16'h4100, 16'h0000, 1'b0, 1'b0, 16'h4000, 8'h5A}, // R2
    {4'd7,  1'b0, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h4000, 8'h5A}, // R7
    {4'd6,  1'b1, 3'd2, 16'h0001, 16'h0000, 1'b0, 1'b0, 16'h0001, 8'h5A}, // R6
    {4'd6,  1'b0, 3'd1, 16'h0000, 16'h0040, 1'b0, 1'b0, 16'h4040, 8'h5A}, // R6
    {4'd6,  1'b0, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h4040, 8'h5A}, // R6
    {4'd3,  1'b0, 3'd1, 16'h0000, 16'h6008, 1'b0, 1'b0, 16'h4040, 8'h5A}, // R3
    {4'd8,  1'b0, 3'd1, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h6040, 8'h5A}, // R8
    {4'd8,  1'b0, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h6040, 8'h5A}, // R8
    {4'd9,  1'b0, 3'd1, 16'h0000, 16'h0001, 1'b0, 1'b1, 16'h6041, 8'hC3}, // R9
    {4'd9,  1'b1, 3'd1, 16'h6041, 16'h0000, 1'b0, 1'b0, 16'h4000, 8'h5A}, // R9
    {4'd7,  1'b0, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h4000, 8'h5A}, // R7
    {4'd5,  1'b1, 3'd0, 16'h0028, 16'h0000, 1'b0, 1'b0, 16'h0028, 8'h5A}, // R5
    {4'd5,  1'b0, 3'd1, 16'h0000, 16'h0001, 1'b0, 1'b0, 16'h4001, 8'hC3}, // R5
    {4'd5,  1'b0, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h4001, 8'hC3}, // R5
    {4'd7,  1'b1, 3'd1, 16'h4001, 16'h0000, 1'b0, 1'b0, 16'h4000, 8'h5A}, // R7
    {4'd4,  1'b1, 3'd0, 16'h00A0, 16'h0000, 1'b0, 1'b0, 16'h00A0, 8'h5A}, // R4
    {4'd4,  1'b0, 3'd1, 16'h0000, 16'h0001, 1'b0, 1'b0, 16'h4001, 8'hC3}, // R4
    {4'd4,  1'b0, 3'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h4001, 8'hC3}, // R4
    {4'd3,  1'b1, 3'd1, 16'h0001, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h5A}  // R3
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [2:0] a, input logic [15:0] d,
                       input logic [15:0] c, input logic u);
    @(negedge clk);
    wr_i = w; addr_i = a; wdata_i = d; cond_i = c; upd_i = u;
    @(posedge clk);
    #1;
    wr_i = 1'b0; cond_i = '0; upd_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "irq", 32'(irq_o), 32'h0);
    chk("R1", "vec", 32'(vec_o), 32'h0);
    for (int a = 0; a < 5; a++) begin
      addr_i = 3'(a);
      #0.1;
      chk("R1", "reg", 32'(rdata_o), 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 29; i++) begin
      logic [65:0] e;
      string r;
      e = TBL[i];
      r = $sformatf("R%0d", e[65:62]);
      drive(e[61], e[60:58], e[57:42], e[41:26], e[25]);
      chk(r, $sformatf("step %0d irq", i), 32'(irq_o), 32'(e[24]));
      chk(r, $sformatf("step %0d rdata", i), 32'(rdata_o), 32'(e[23:8]));
      chk(r, $sformatf("step %0d vec", i), 32'(vec_o), 32'(e[7:0]));
    end
    // R2: set and clear of the same bit in one cycle, set wins
    drive(1'b1, 3'd1, 16'h0002, 16'h0002, 1'b0);
    chk("R2", "set beats clear", 32'(rdata_o), 32'h0002);
    // R1: reset mid-run restores the reset state
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R1", "irq after reset", 32'(irq_o), 32'h0);
    chk("R1", "status after reset", 32'(rdata_o), 32'h0);
    addr_i = 3'd2;
    #0.1;
    chk("R1", "mask after reset", 32'(rdata_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule